// File: doc/BRIEF.md
# Partial-Retention Power-Down Controller

This block sits in front of a word-addressed low-power memory array and handles power-down with optional partial retention. An active-low power-down pin puts the array into a power-down state. The state lasts for as long as the pin is held low. While the block is powered down, every access from the user port is refused.

When the pin returns high, the block does not resume normal operation at once. A scrub sequencer first writes an invalid marker to every word outside the retained window. The retained window is a low address range, and its size is chosen by the retention mode. A busy flag stays high until the sequencer reaches the top of the array, and user accesses are refused during that time.

The retention mode can only be changed through a single configuration write strobe. That strobe stands in for the full configuration-set operation. There are three modes:
- **No retention:** the default after reset.
- **Small window:** one eighth of the array is kept.
- **Large window:** one quarter of the array is kept.

At the full size (`ADDR_W` = 21, 2M words of 16 bits), the small window covers words 0x000000–0x03FFFF and the large window covers 0x000000–0x07FFFF. The default `ADDR_W` is small, for simulation.

Top module: `pdr_ctrl`

## Requirements
- R1: After synchronous reset, `busy` is low, `rd_data` is zero and the retention mode is no-retention (code 0).
- R2: While the block is running and not busy, a write (`acc_en`=1, `acc_we`=1) stores `acc_wdata` at `acc_addr`. A read (`acc_en`=1, `acc_we`=0) returns the stored word on `rd_data` one clock after the edge that samples it. In any other cycle `rd_data` is zero.
- R3: A clock edge that samples `pd_n` low puts the block into power-down from the next cycle. It stays powered down while `pd_n` is low. While powered down, writes leave the array unchanged and reads return zero.
- R4: The first edge that samples `pd_n` high while the block is powered down raises `busy` for the next cycle. `busy` then stays high for exactly DEPTH − BASE cycles, where DEPTH = 2^`ADDR_W` and BASE is the size of the retained window.
- R5: In mode code 0 (no retention, BASE = 0), every word reads as `INVALID` (default 16'hDEAD) after wake.
- R6: In mode code 1 (small window, BASE = DEPTH/8), words below BASE keep their contents across power-down. All other words read as `INVALID`.
- R7: In mode code 2 (large window, BASE = DEPTH/4), words below BASE keep their contents across power-down. All other words read as `INVALID`.
- R8: A configuration write (`cfg_we`=1) takes effect only while the block is running and not busy. Code 3 is ignored. The mode never holds code 3 and never changes while the block is powered down or busy.
- R9: While `busy` is high, writes leave the array unchanged and reads return zero.
- R10: An edge that samples `pd_n` low during the scrub aborts the scrub and returns the block to power-down. The next wake restarts the scrub from BASE and runs it for the full DEPTH − BASE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down request, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Retention mode code: 0 none, 1 small, 2 large |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, zero unless an accepted read completed |
| busy | output | 1 | Scrub in progress |

## Verification
The assertions check these rules on every cycle:
- reads issued while powered down or busy come back as zero;
- `busy` only rises straight out of power-down;
- a low `pd_n` always clears `busy` on the next cycle;
- the mode never becomes code 3 and never moves while powered down or busy;
- the scrub pointer never enters the retained window.

The bench's scenarios are needed for the rest:
- the exact busy length for each mode;
- which words survive each mode;
- that writes refused while powered down or busy truly leave the array untouched;
- that an aborted scrub restarts from the bottom of its range.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_SMALL = 2'b01,
    MODE_LARGE = 2'b10
  } ret_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_DOWN  = 2'b01,
    ST_SCRUB = 2'b10
  } pd_state_e;
endpackage

// File: rtl/pdr_ram.sv
module pdr_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-before-write, maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/pdr_seq.sv
module pdr_seq
  import pdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n,
  input  logic [ADDR_W-1:0] base,
  output pd_state_e         state,
  output logic [ADDR_W-1:0] scrub_addr,
  output logic              scrub_we
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      ptr   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (!pd_n) state <= ST_DOWN;
        end
        ST_DOWN: begin
          if (pd_n) begin
            state <= ST_SCRUB;
            ptr   <= base;
          end
        end
        ST_SCRUB: begin
          if (!pd_n) begin
            state <= ST_DOWN;
          end else begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) state <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign scrub_addr = ptr;
  assign scrub_we   = (state == ST_SCRUB);
endmodule

// File: rtl/pdr_ctrl.sv
module pdr_ctrl
  import pdr_pkg::*;
#(
  parameter int                DATA_W  = 16,
  parameter int                ADDR_W  = 8,
  parameter logic [DATA_W-1:0] INVALID = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int                DEPTH      = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BASE_SMALL = ADDR_W'(DEPTH >> 3);
  localparam logic [ADDR_W-1:0] BASE_LARGE = ADDR_W'(DEPTH >> 2);

  ret_mode_e         mode_q;
  pd_state_e         state;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] scrub_addr;
  logic              scrub_we;
  logic              run;
  logic              asleep;
  logic              acc_ok;
  logic              rd_ok_q;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wd;
  logic [DATA_W-1:0] ram_q;

  assign run    = (state == ST_RUN);
  assign asleep = (state == ST_DOWN);
  assign busy   = (state == ST_SCRUB);

  // retention mode register
  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_NONE;
    else if (cfg_we && run && cfg_mode != 2'b11) mode_q <= ret_mode_e'(cfg_mode);
  end

  always_comb begin
    case (mode_q)
      MODE_SMALL: base = BASE_SMALL;
      MODE_LARGE: base = BASE_LARGE;
      default:    base = '0;
    endcase
  end

  pdr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .pd_n       (pd_n),
    .base       (base),
    .state      (state),
    .scrub_addr (scrub_addr),
    .scrub_we   (scrub_we)
  );

  // access gating and array port mux
  assign acc_ok   = acc_en && run;
  assign ram_we   = scrub_we || (acc_ok && acc_we);
  assign ram_addr = scrub_we ? scrub_addr : acc_addr;
  assign ram_wd   = scrub_we ? INVALID : acc_wdata;

  pdr_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wd),
    .q     (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_ok_q <= 1'b0;
    else     rd_ok_q <= acc_ok && !acc_we;
  end

  assign rd_data = rd_ok_q ? ram_q : '0;
endmodule

// File: rtl/pdr_ctrl_chk.sv
module pdr_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pd_n,
  input logic              acc_en,
  input logic              acc_we,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              asleep,
  input logic [1:0]        mode_q,
  input logic [ADDR_W-1:0] scrub_addr,
  input logic [ADDR_W-1:0] base
);
  AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst) |-> !busy && rd_data == '0); // R1
  AST_GATED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we && (asleep || busy)) |=> rd_data == '0); // R3 R9
  AST_BUSY_FROM_DOWN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(asleep)); // R4
  AST_PD_KILLS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> !busy); // R10
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (asleep || busy) |=> $stable(mode_q)); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'b11); // R8
  AST_SCRUB_ABOVE_BASE: assert property (@(posedge clk) disable iff (rst)
    busy |-> scrub_addr >= base); // R6 R7
endmodule

bind pdr_ctrl pdr_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pd_n       (pd_n),
  .acc_en     (acc_en),
  .acc_we     (acc_we),
  .rd_data    (rd_data),
  .busy       (busy),
  .asleep     (asleep),
  .mode_q     (mode_q),
  .scrub_addr (scrub_addr),
  .base       (base)
);

// File: tb/tb_pdr_ctrl.sv
module tb_pdr_ctrl;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pd_n = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_mode = 2'b00;
  logic          acc_en = 1'b0;
  logic          acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] rd_data;
  logic          busy;

  int nvec = 0;
  int nerr = 0;
  int bcnt = 0;

  always #2 clk = ~clk;

  pdr_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .pd_n(pd_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .busy(busy)
  );

  always @(negedge clk) if (busy) bcnt++;

  function automatic logic [DW-1:0] pat(input int a, input logic [DW-1:0] salt);
    return DW'(a * 16'h0101) ^ salt;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = AW'(a); acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] q);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = AW'(a);
    @(negedge clk);
    q = rd_data;
    acc_en = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill(input logic [DW-1:0] salt);
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, salt));
  endtask

  task automatic check_all(input int lim, input logic [DW-1:0] salt, input string tag);
    logic [DW-1:0] q;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, q);
      chk(tag, {16'h0, q}, {16'h0, (a < lim) ? pat(a, salt) : 16'hDEAD});
    end
  endtask

  task automatic go_down();
    @(negedge clk);
    pd_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wake();
    @(negedge clk);
    bcnt = 0;
    pd_n = 1'b1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [DW-1:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", {31'h0, busy}, 32'h0);
    chk("R1 rd_data after reset", {16'h0, rd_data}, 32'h0);

    // R2: plain write/read
    fill(16'h5A3C);
    check_all(DEPTH, 16'h5A3C, "R2 readback");

    // R5 + R4: default mode, no retention
    go_down();
    wake();
    @(negedge clk);
    chk("R4 busy rises after wake", {31'h0, busy}, 32'h1);
    wait_idle();
    chk("R4 busy length mode0", bcnt, DEPTH);
    check_all(0, 16'h5A3C, "R5 all invalid");

    // R6 + R3 + R8: small window
    fill(16'h1357);
    cfg(2'b01);
    cfg(2'b11);                        // R8: code 3 ignored
    go_down();
    wr(2, 16'h7777);                   // R3: write while down ignored
    rd(5, q);
    chk("R3 read while down", {16'h0, q}, 32'h0);
    cfg(2'b10);                        // R8: ignored while down
    wake();
    wait_idle();
    chk("R4 R8 busy length mode1", bcnt, DEPTH - DEPTH / 8);
    check_all(DEPTH / 8, 16'h1357, "R6 R3 small window");

    // R7 + R9: large window
    fill(16'h2468);
    cfg(2'b10);
    go_down();
    wake();
    wr(3, 16'h7777);                   // R9: write while busy ignored
    rd(4, q);
    chk("R9 read while busy", {16'h0, q}, 32'h0);
    cfg(2'b01);                        // R8: ignored while busy
    wait_idle();
    chk("R4 R8 busy length mode2", bcnt, DEPTH - DEPTH / 4);
    check_all(DEPTH / 4, 16'h2468, "R7 R9 large window");

    // R10: abort scrub and restart
    fill(16'h0F0F);
    go_down();
    wake();
    repeat (10) @(negedge clk);
    pd_n = 1'b0;
    @(negedge clk);
    chk("R10 busy drops on pd", {31'h0, busy}, 32'h0);
    repeat (3) @(negedge clk);
    wake();
    wait_idle();
    chk("R10 full rescrub length", bcnt, DEPTH - DEPTH / 4);
    check_all(DEPTH / 4, 16'h0F0F, "R10 contents after restart");

    summary();
  end
endmodule